// File: doc/BRIEF.md
# Device Interrupt Pin to Shared Line Mapper

This block turns the interrupt pin (INTA..INTD) of a device in any of 32 slots into one of eight shared interrupt lines, numbered 0 to 7. Seven upper slots (25 to 31) each have a 16-bit route register. Each of the four pins of such a slot has a field in that register that picks its line. The route registers sit in a 16 KiB little-endian register region. Software reaches them through a plain read/write port with 1-, 2- or 4-byte accesses.

Slot 30 is hard-wired. Its pins always land on lines 4 to 7, and its register reads as zero. Every slot below 25 uses a rotating default, so lines 0 to 3 are never used by those slots.

Lookups travel on a valid/ready stream. A request carries a slot and a pin. The answer comes back one cycle after acceptance on an output stream that honours back-pressure. A stalled answer is held unchanged, and no new request is taken while the answer is stalled. The answer always reflects the registers as they stand in the cycle of acceptance.

Top module: `irq_pin_router`

## Requirements
- R1: After reset, every writable route register reads 16'h3210, every other byte of the region reads zero, and `lk_out_valid` is low.
- R2: For slots 25 to 29 and 31, the line for pin n is bits [4n+2:4n] of that slot's route register, and bit 4n+3 has no effect.
- R3: Slot 30 maps pin p to line 4+p. Its register always reads zero, and writes to it have no effect on reads or lookups.
- R4: A slot below 25 maps pin p of slot s to line ((s+p) mod 4)+4.
- R5: A register write is seen by every lookup accepted in a later cycle.
- R6: `reg_size` encodes the access length as 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, and 3 = 4 bytes. Data is little-endian: byte i of `reg_wdata`/`reg_rdata` belongs to address addr+i. Read bytes beyond the access length return zero.
- R7: Only the low 14 bits of `reg_addr` select a byte, so any address aliases into the 16 KiB region.
- R8: An access is cut short at the region end. Lanes whose address would pass 0x3FFF are neither written nor read (they read zero), and nothing wraps to offset 0.
- R9: The register of slot s occupies bytes (0x3FFC + 2*(s-25)) mod 0x4000 and the byte after it, low byte first. So slot 25 sits at 0x3FFC, slot 26 at 0x3FFE, slot 27 at 0x0000, and so on up to slot 31 at 0x0008. All other bytes are not stored: they read zero and writes to them are dropped.
- R10: A lookup is accepted when `lk_in_valid` and `lk_in_ready` are both high, where `lk_in_ready` = !`lk_out_valid` || `lk_out_ready`. The answer is valid in the next cycle, and it holds stable while `lk_out_valid` is high and `lk_out_ready` is low.
- R11: `reg_rdata` loads in the cycle after `reg_rd_en` is high and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | 16 | Byte address (low 14 bits used) |
| reg_size | input | 2 | Access length code |
| reg_wdata | input | 32 | Write data, little-endian |
| reg_rdata | output | 32 | Read data, registered |
| lk_in_valid | input | 1 | Lookup request valid |
| lk_in_ready | output | 1 | Lookup request ready |
| lk_slot | input | 5 | Device slot number |
| lk_pin | input | 2 | Pin index, 0 = INTA |
| lk_out_valid | output | 1 | Lookup answer valid |
| lk_out_ready | input | 1 | Lookup answer ready |
| lk_pirq | output | 3 | Shared line number |

## Verification
The hardest case to reach from the ports is an access that runs off the end of the region. The layout places slots 27 onward at offset 0, so a clipped access differs from a wrapped one only when the bytes just past the end hold data that is not zero. The stimulus first writes slot 27 with a distinctive value. It then issues 4-byte reads and writes at 0x3FFE and checks that slot 27 is untouched and that the upper read lanes come back as zero. A stalled lookup answer is also built on purpose: `lk_out_ready` is held low while a second request waits, and the bench confirms the first answer holds and the second is taken only when the answer drains.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

  typedef enum logic [1:0] {
    ACC_B1  = 2'd0,
    ACC_B2  = 2'd1,
    ACC_B4  = 2'd2,
    ACC_B4X = 2'd3
  } acc_size_e;

  function automatic int unsigned acc_len(input logic [1:0] code);
    case (acc_size_e'(code))
      ACC_B1:  return 1;
      ACC_B2:  return 2;
      default: return 4;
    endcase
  endfunction

endpackage

// File: rtl/irq_route_regs.sv
module irq_route_regs
  import irq_route_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int REGION_AW   = 14,
  parameter int ROUTE_BASE  = 16380,
  parameter int NUM_ROUTED  = 7,
  parameter int FIXED_IDX   = 5,
  parameter int REG_W       = 16,
  parameter int DATA_BYTES  = 4,
  parameter logic [REG_W-1:0] DEFAULT_ROUTE = 16'h3210
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                wr_en,
  input  logic                                rd_en,
  input  logic [ADDR_W-1:0]                   addr,
  input  logic [1:0]                          size,
  input  logic [DATA_BYTES*8-1:0]             wdata,
  output logic [DATA_BYTES*8-1:0]             rdata,
  output logic [NUM_ROUTED-1:0][REG_W-1:0]    route_o
);

  localparam int REG_BYTES   = REG_W / 8;
  localparam int REGION_SIZE = 1 << REGION_AW;

  logic [REGION_AW-1:0]                   base_a;
  logic [DATA_BYTES-1:0]                  lane_en;
  logic [DATA_BYTES-1:0][REGION_AW-1:0]   lane_a;
  logic [DATA_BYTES*8-1:0]                rd_next;
  logic                                   unused_addr_hi;

  function automatic logic [REGION_AW-1:0] byte_off(input int k, input int j);
    return REGION_AW'(ROUTE_BASE + k * REG_BYTES + j);
  endfunction

  assign base_a         = addr[REGION_AW-1:0];
  assign unused_addr_hi = ^addr;

  always_comb begin
    for (int i = 0; i < DATA_BYTES; i++) begin
      lane_a[i]  = base_a + REGION_AW'(i);
      lane_en[i] = (i < int'(acc_len(size))) &&
                   (({1'b0, base_a} + (REGION_AW+1)'(i)) < (REGION_AW+1)'(REGION_SIZE));
    end
  end

  for (genvar k = 0; k < NUM_ROUTED; k++) begin : g_route
    if (k == FIXED_IDX) begin : g_fixed
      assign route_o[k] = '0;
    end else begin : g_store
      logic [REG_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          q <= DEFAULT_ROUTE;
        end else if (wr_en) begin
          for (int j = 0; j < REG_BYTES; j++) begin
            for (int i = 0; i < DATA_BYTES; i++) begin
              if (lane_en[i] && lane_a[i] == byte_off(k, j)) begin
                q[8*j +: 8] <= wdata[8*i +: 8];
              end
            end
          end
        end
      end
      assign route_o[k] = q;
    end
  end

  always_comb begin
    rd_next = '0;
    for (int i = 0; i < DATA_BYTES; i++) begin
      for (int k = 0; k < NUM_ROUTED; k++) begin
        for (int j = 0; j < REG_BYTES; j++) begin
          if (lane_en[i] && lane_a[i] == byte_off(k, j)) begin
            rd_next[8*i +: 8] = route_o[k][8*j +: 8];
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
    end else if (rd_en) begin
      rdata <= rd_next;
    end
  end

endmodule

// File: rtl/irq_route_decode.sv
module irq_route_decode #(
  parameter int SLOTS      = 32,
  parameter int PINS       = 4,
  parameter int PIRQ_W     = 3,
  parameter int FIELD_W    = 4,
  parameter int FIRST_SLOT = 25,
  parameter int NUM_ROUTED = 7,
  parameter int FIXED_SLOT = 30,
  parameter int REG_W      = 16
) (
  input  logic [NUM_ROUTED-1:0][REG_W-1:0]         route_i,
  output logic [SLOTS-1:0][PINS-1:0][PIRQ_W-1:0]   table_o
);

  localparam int HALF = 1 << (PIRQ_W - 1);

  logic unused_route_bits;
  assign unused_route_bits = ^route_i;

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    for (genvar p = 0; p < PINS; p++) begin : g_pin
      if (s == FIXED_SLOT) begin : g_fixed
        assign table_o[s][p] = PIRQ_W'(HALF + p);
      end else if (s >= FIRST_SLOT && s < FIRST_SLOT + NUM_ROUTED) begin : g_reg
        assign table_o[s][p] = route_i[s - FIRST_SLOT][FIELD_W*p +: PIRQ_W];
      end else begin : g_rot
        assign table_o[s][p] = PIRQ_W'(((s + p) % HALF) + HALF);
      end
    end
  end

endmodule

// File: rtl/irq_route_lookup.sv
module irq_route_lookup #(
  parameter int SLOTS  = 32,
  parameter int PINS   = 4,
  parameter int PIRQ_W = 3,
  parameter int SLOT_W = $clog2(SLOTS),
  parameter int PIN_W  = $clog2(PINS)
) (
  input  logic                                    clk,
  input  logic                                    rst_n,
  input  logic [SLOTS-1:0][PINS-1:0][PIRQ_W-1:0]  table_i,
  input  logic                                    in_valid,
  output logic                                    in_ready,
  input  logic [SLOT_W-1:0]                       in_slot,
  input  logic [PIN_W-1:0]                        in_pin,
  output logic                                    out_valid,
  input  logic                                    out_ready,
  output logic [PIRQ_W-1:0]                       out_pirq
);

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_pirq  <= '0;
    end else if (in_valid && in_ready) begin
      out_valid <= 1'b1;
      out_pirq  <= table_i[in_slot][in_pin];
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/irq_pin_router.sv
module irq_pin_router #(
  parameter int SLOTS      = 32,
  parameter int PINS       = 4,
  parameter int PIRQ_W     = 3,
  parameter int FIELD_W    = 4,
  parameter int FIRST_SLOT = 25,
  parameter int NUM_ROUTED = 7,
  parameter int FIXED_SLOT = 30,
  parameter int ADDR_W     = 16,
  parameter int REGION_AW  = 14,
  parameter int ROUTE_BASE = 16380,
  parameter int DATA_BYTES = 4,
  parameter int SLOT_W     = $clog2(SLOTS),
  parameter int PIN_W      = $clog2(PINS)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     reg_wr_en,
  input  logic                     reg_rd_en,
  input  logic [ADDR_W-1:0]        reg_addr,
  input  logic [1:0]               reg_size,
  input  logic [DATA_BYTES*8-1:0]  reg_wdata,
  output logic [DATA_BYTES*8-1:0]  reg_rdata,
  input  logic                     lk_in_valid,
  output logic                     lk_in_ready,
  input  logic [SLOT_W-1:0]        lk_slot,
  input  logic [PIN_W-1:0]         lk_pin,
  output logic                     lk_out_valid,
  input  logic                     lk_out_ready,
  output logic [PIRQ_W-1:0]        lk_pirq
);

  localparam int REG_W     = PINS * FIELD_W;
  localparam int FIXED_IDX = FIXED_SLOT - FIRST_SLOT;

  logic [NUM_ROUTED-1:0][REG_W-1:0]        route;
  logic [SLOTS-1:0][PINS-1:0][PIRQ_W-1:0]  route_table;

  irq_route_regs #(
    .ADDR_W     (ADDR_W),
    .REGION_AW  (REGION_AW),
    .ROUTE_BASE (ROUTE_BASE),
    .NUM_ROUTED (NUM_ROUTED),
    .FIXED_IDX  (FIXED_IDX),
    .REG_W      (REG_W),
    .DATA_BYTES (DATA_BYTES),
    .DEFAULT_ROUTE (REG_W'(16'h3210))
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (reg_wr_en),
    .rd_en   (reg_rd_en),
    .addr    (reg_addr),
    .size    (reg_size),
    .wdata   (reg_wdata),
    .rdata   (reg_rdata),
    .route_o (route)
  );

  irq_route_decode #(
    .SLOTS      (SLOTS),
    .PINS       (PINS),
    .PIRQ_W     (PIRQ_W),
    .FIELD_W    (FIELD_W),
    .FIRST_SLOT (FIRST_SLOT),
    .NUM_ROUTED (NUM_ROUTED),
    .FIXED_SLOT (FIXED_SLOT),
    .REG_W      (REG_W)
  ) u_decode (
    .route_i (route),
    .table_o (route_table)
  );

  irq_route_lookup #(
    .SLOTS  (SLOTS),
    .PINS   (PINS),
    .PIRQ_W (PIRQ_W),
    .SLOT_W (SLOT_W),
    .PIN_W  (PIN_W)
  ) u_lookup (
    .clk       (clk),
    .rst_n     (rst_n),
    .table_i   (route_table),
    .in_valid  (lk_in_valid),
    .in_ready  (lk_in_ready),
    .in_slot   (lk_slot),
    .in_pin    (lk_pin),
    .out_valid (lk_out_valid),
    .out_ready (lk_out_ready),
    .out_pirq  (lk_pirq)
  );

endmodule

// File: rtl/irq_pin_router_chk.sv
module irq_pin_router_chk #(
  parameter int FIRST_SLOT = 25,
  parameter int FIXED_SLOT = 30
) (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_rd_en,
  input logic [1:0]  reg_size,
  input logic [31:0] reg_rdata,
  input logic        lk_in_valid,
  input logic        lk_in_ready,
  input logic [4:0]  lk_slot,
  input logic [1:0]  lk_pin,
  input logic        lk_out_valid,
  input logic        lk_out_ready,
  input logic [2:0]  lk_pirq
);

  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_out_valid && !lk_out_ready |=> lk_out_valid && $stable(lk_pirq));

  // R10
  accept_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_in_valid && lk_in_ready |=> lk_out_valid);

  // R3
  fixed_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_in_valid && lk_in_ready && lk_slot == 5'(FIXED_SLOT)
    |=> lk_pirq == {1'b1, $past(lk_pin)});

  // R4
  rotate_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_in_valid && lk_in_ready && lk_slot < 5'(FIRST_SLOT) |=> lk_pirq[2]);

  // R6
  narrow_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd_en && reg_size == 2'd0 |=> reg_rdata[31:8] == 24'd0);

  // R11
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd_en |=> $stable(reg_rdata));

endmodule

bind irq_pin_router irq_pin_router_chk #(
  .FIRST_SLOT (FIRST_SLOT),
  .FIXED_SLOT (FIXED_SLOT)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .reg_rd_en    (reg_rd_en),
  .reg_size     (reg_size),
  .reg_rdata    (reg_rdata),
  .lk_in_valid  (lk_in_valid),
  .lk_in_ready  (lk_in_ready),
  .lk_slot      (lk_slot),
  .lk_pin       (lk_pin),
  .lk_out_valid (lk_out_valid),
  .lk_out_ready (lk_out_ready),
  .lk_pirq      (lk_pirq)
);

// File: tb/test_irq_pin_router.sv
module test_irq_pin_router;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic        reg_rd_en = 1'b0;
  logic [15:0] reg_addr = '0;
  logic [1:0]  reg_size = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        lk_in_valid = 1'b0;
  logic        lk_in_ready;
  logic [4:0]  lk_slot = '0;
  logic [1:0]  lk_pin = '0;
  logic        lk_out_valid;
  logic        lk_out_ready = 1'b1;
  logic [2:0]  lk_pirq;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  irq_pin_router i_irq_pin_router (
    .clk (clk), .rst_n (rst_n),
    .reg_wr_en (reg_wr_en), .reg_rd_en (reg_rd_en), .reg_addr (reg_addr),
    .reg_size (reg_size), .reg_wdata (reg_wdata), .reg_rdata (reg_rdata),
    .lk_in_valid (lk_in_valid), .lk_in_ready (lk_in_ready), .lk_slot (lk_slot),
    .lk_pin (lk_pin), .lk_out_valid (lk_out_valid), .lk_out_ready (lk_out_ready),
    .lk_pirq (lk_pirq)
  );

  // {slot, pin, expected line} after reset
  localparam logic [9:0] VEC [12] = '{
    {5'd0,  2'd0, 3'd4}, {5'd3,  2'd3, 3'd6}, {5'd5,  2'd2, 3'd7},
    {5'd24, 2'd1, 3'd5}, {5'd12, 2'd2, 3'd6}, {5'd25, 2'd0, 3'd0},
    {5'd25, 2'd3, 3'd3}, {5'd26, 2'd1, 3'd1}, {5'd31, 2'd2, 3'd2},
    {5'd29, 2'd1, 3'd1}, {5'd30, 2'd0, 3'd4}, {5'd30, 2'd3, 3'd7}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [1:0] sz, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_size = sz; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, input logic [1:0] sz, output logic [31:0] d);
    @(negedge clk);
    reg_rd_en = 1'b1; reg_addr = a; reg_size = sz;
    @(negedge clk);
    reg_rd_en = 1'b0;
    d = reg_rdata;
  endtask

  task automatic look(input logic [4:0] s, input logic [1:0] p, output logic [2:0] q);
    @(negedge clk);
    lk_in_valid = 1'b1; lk_slot = s; lk_pin = p;
    @(negedge clk);
    lk_in_valid = 1'b0;
    q = lk_pirq;
  endtask

  initial begin
    logic [31:0] d;
    logic [2:0]  q;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk("R1 out_valid", {31'd0, lk_out_valid}, 32'd0);
    rd(16'h3FFC, 2'd2, d); chk("R1 R9 slots 25/26", d, 32'h3210_3210);
    rd(16'h0100, 2'd2, d); chk("R1 unused bytes", d, 32'd0);

    // R2 R3 R4 default lookups from the table
    for (int v = 0; v < 12; v++) begin
      look(VEC[v][9:5], VEC[v][4:3], q);
      chk("R2 R3 R4 table lookup", {29'd0, q}, {29'd0, VEC[v][2:0]});
    end

    // R3 fixed slot reads zero, write ignored
    rd(16'h0004, 2'd2, d); chk("R3 R9 slot29/30 read", d, 32'h0000_3210);
    wr(16'h0006, 2'd1, 32'h0000_FFFF);
    rd(16'h0006, 2'd1, d); chk("R3 write ignored", d, 32'd0);
    look(5'd30, 2'd2, q); chk("R3 lookup after write", {29'd0, q}, 32'd6);

    // R2 R5 field decode with bit 3 ignored
    wr(16'h0002, 2'd1, 32'h0000_F5A3);
    look(5'd28, 2'd0, q); chk("R5 slot28 pin0", {29'd0, q}, 32'd3);
    look(5'd28, 2'd1, q); chk("R2 slot28 pin1 bit3", {29'd0, q}, 32'd2);
    look(5'd28, 2'd3, q); chk("R2 slot28 pin3", {29'd0, q}, 32'd7);

    // R6 byte write, narrow reads
    wr(16'h0003, 2'd0, 32'h0000_000C);
    rd(16'h0003, 2'd0, d); chk("R6 byte read", d, 32'h0000_000C);
    rd(16'h0002, 2'd1, d); chk("R6 half read", d, 32'h0000_0CA3);
    look(5'd28, 2'd2, q); chk("R2 slot28 pin2", {29'd0, q}, 32'd4);

    // R11 rdata holds without a read
    wr(16'h0002, 2'd1, 32'h0000_1111);
    chk("R11 rdata hold", reg_rdata, 32'h0000_0CA3);

    // R7 address aliasing
    wr(16'hC000, 2'd1, 32'h0000_7777);
    rd(16'h0000, 2'd1, d); chk("R7 alias write", d, 32'h0000_7777);
    look(5'd27, 2'd1, q); chk("R7 slot27 pin1", {29'd0, q}, 32'd7);

    // R8 clipping at region end
    wr(16'h3FFE, 2'd2, 32'h1111_4567);
    rd(16'h0000, 2'd1, d); chk("R8 no wrap write", d, 32'h0000_7777);
    rd(16'h3FFE, 2'd2, d); chk("R8 clipped read", d, 32'h0000_4567);

    // R9 unused bytes drop writes
    wr(16'h0100, 2'd2, 32'hDEAD_BEEF);
    rd(16'h0100, 2'd2, d); chk("R9 unused write", d, 32'd0);

    // R6 size code 3 acts as 4 bytes
    wr(16'h0004, 2'd3, 32'h9999_1234);
    rd(16'h0004, 2'd2, d); chk("R6 size3 write", d, 32'h0000_1234);

    // R10 back-pressure
    lk_out_ready = 1'b0;
    look(5'd0, 2'd1, q); chk("R10 first answer", {29'd0, q}, 32'd5);
    lk_in_valid = 1'b1; lk_slot = 5'd3; lk_pin = 2'd0;
    #1 chk("R10 ready low", {31'd0, lk_in_ready}, 32'd0);
    @(negedge clk);
    chk("R10 held answer", {28'd0, lk_out_valid, lk_pirq}, 32'h0000_000D);
    lk_out_ready = 1'b1;
    @(negedge clk);
    lk_in_valid = 1'b0;
    chk("R10 second answer", {28'd0, lk_out_valid, lk_pirq}, 32'h0000_000F);
    @(negedge clk);
    chk("R10 drained", {31'd0, lk_out_valid}, 32'd0);

    // R1 reset again restores defaults
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    rd(16'h0002, 2'd1, d); chk("R1 reload default", d, 32'h0000_3210);
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule